// File: doc/BRIEF.md
# Endpoint Handshake Mode Controller

This block keeps the mode register of one non-control USB endpoint and chooses the handshake that the endpoint returns for each token. A serial interface engine presents one strobe per decoded token. The strobe carries the token kind and a flag that says whether the data packet arrived without CRC, bit-stuff or PID errors. One cycle later the block answers with a registered handshake selection: no response, ACK, NAK or STALL. When the engine later reports that an acknowledged transaction has finished, the block sets a sticky ACKed flag. If the mode was a one-shot accept mode, the block also drops the endpoint back to NAK-everything without any CPU action.

Firmware reads and writes the 8-bit register through a simple write strobe and a read bus that always shows the register. The register has four parts. Bit 7 is the stall request. Bit 4 is the ACKed flag: it is read-only to the CPU, except that the CPU can clear it. Bits 3:0 hold the mode. Bits 6:5 are not stored.

Top module: `ep_hs_ctrl`

## Requirements
- R1: After a synchronous reset the register reads 8'h00, `ep_acked` is 0 and `hs_valid` is 0.
- R2: Bits 6:5 always read as 0 and ignore writes. A CPU write loads bit 7 and bits 3:0 directly. Writing 1 to bit 4 never sets the ACKed flag.
- R3: With mode 4'b0000 the endpoint is disabled, and every token gets handshake code NONE.
- R4: Each token strobe gives exactly one `hs_valid` pulse on the next clock edge. The handshake codes are NONE=2'b00, ACK=2'b01, NAK=2'b10 and STALL=2'b11. The token kinds are OUT=2'b01, IN=2'b10 and SETUP=2'b11. Mode 4'b0001 NAKs both IN and OUT. Mode 4'b1011 NAKs IN. Mode 4'b1101 NAKs OUT. Any mode code not listed NAKs both IN and OUT.
- R5: In mode 4'b1011 a good OUT packet gets ACK.
- R6: When the transaction-done strobe comes with `xact_ok`=1 after an ACKed OUT in mode 4'b1011, the mode becomes 4'b0001 and the ACKed flag (bit 4) is set. After that, OUT tokens get NAK. If the done strobe comes with `xact_ok`=0, nothing changes.
- R7: When bit 7 is 1, the ACK that a mode would give becomes STALL. A stalled transaction never sets the flag and never changes the mode. In modes that do not give ACK, bit 7 has no effect.
- R8: In mode 4'b1101 an IN token gets ACK. A successful done strobe after it sets the mode to 4'b0001 and sets the flag.
- R9: An OUT packet with `pkt_good`=0 gets NONE. A following done strobe changes neither the mode nor the flag.
- R10: SETUP tokens always get NONE on this endpoint.
- R11: A CPU write with bit 4 = 0 clears the ACKed flag.
- R12: If a CPU write and a hardware update happen in the same cycle, the CPU value wins for the mode. The hardware set of the flag wins over a CPU clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_wr_data | input | 8 | CPU write data |
| cpu_rd_data | output | 8 | Current register value |
| tok_valid | input | 1 | One-cycle strobe for a decoded token |
| tok_kind | input | 2 | Token kind (OUT 01, IN 10, SETUP 11) |
| pkt_good | input | 1 | Data packet received without errors |
| xact_done | input | 1 | Transaction finished strobe |
| xact_ok | input | 1 | Transaction finished with an acknowledge |
| hs_valid | output | 1 | Handshake selection valid, one cycle |
| hs_code | output | 2 | Handshake selection (NONE/ACK/NAK/STALL) |
| ep_acked | output | 1 | Sticky ACKed-transaction flag |

## Verification
Some wrong internal states show up within one cycle. A wrongly decoded mode or stall bit gives the wrong `hs_code` on the cycle right after the token strobe. A lost or spurious pending record is slower: it shows only when the done strobe arrives, as a register readback with the wrong mode or flag one edge after the strobe. The next token after that then shows it again as a NAK where an ACK was expected, or the reverse. Write arbitration faults show only when a CPU write and a done strobe land together, so that case is driven on purpose and read back on the following cycle.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
  localparam int REG_W   = 8;
  localparam int MODE_W  = 4;
  localparam int STALL_B = 7;
  localparam int FLAG_B  = 4;
  localparam int RSV_LO  = 5;
  localparam int RSV_W   = STALL_B - RSV_LO;

  localparam logic [MODE_W-1:0] MODE_OFF     = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_NAK_ALL = 4'b0001;
  localparam logic [MODE_W-1:0] MODE_ACK_OUT = 4'b1011;
  localparam logic [MODE_W-1:0] MODE_ACK_IN  = 4'b1101;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  typedef enum logic [1:0] {
    TOK_NONE  = 2'b00,
    TOK_OUT   = 2'b01,
    TOK_IN    = 2'b10,
    TOK_SETUP = 2'b11
  } tok_e;

  typedef struct packed {
    hs_e  hs;
    logic rearm;
    logic accept;
  } verdict_t;
endpackage

// File: rtl/ep_hs_policy.sv
module ep_hs_policy
  import ep_hs_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              stall,
  input  tok_e              tok,
  input  logic              good,
  output verdict_t          verdict
);
  logic accepts_out;
  logic accepts_in;
  logic off;

  assign off         = (mode == MODE_OFF);
  assign accepts_out = (mode == MODE_ACK_OUT);
  assign accepts_in  = (mode == MODE_ACK_IN);

  always_comb begin
    verdict = '{hs: HS_NONE, rearm: 1'b0, accept: 1'b0};
    unique case (tok)
      TOK_OUT: begin
        if (off || !good) begin
          verdict.hs = HS_NONE;
        end else if (accepts_out) begin
          if (stall) begin
            verdict.hs = HS_STALL;
          end else begin
            verdict.hs     = HS_ACK;
            verdict.accept = 1'b1;
            verdict.rearm  = 1'b1;
          end
        end else begin
          verdict.hs = HS_NAK;
        end
      end
      TOK_IN: begin
        if (off) begin
          verdict.hs = HS_NONE;
        end else if (accepts_in) begin
          if (stall) begin
            verdict.hs = HS_STALL;
          end else begin
            verdict.hs     = HS_ACK;
            verdict.accept = 1'b1;
            verdict.rearm  = 1'b1;
          end
        end else begin
          verdict.hs = HS_NAK;
        end
      end
      default: verdict.hs = HS_NONE;
    endcase
  end
endmodule

// File: rtl/ep_hs_tracker.sv
module ep_hs_tracker
  import ep_hs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tok_valid,
  input  verdict_t verdict,
  input  logic     xact_done,
  input  logic     xact_ok,
  output logic     hs_valid,
  output hs_e      hs_code,
  output logic     hw_set_flag,
  output logic     hw_rearm
);
  logic pend;
  logic pend_rearm;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
    end else begin
      hs_valid <= tok_valid;
      if (tok_valid) hs_code <= verdict.hs;
      else           hs_code <= HS_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      pend_rearm <= 1'b0;
    end else if (tok_valid) begin
      pend       <= verdict.accept;
      pend_rearm <= verdict.rearm;
    end else if (xact_done) begin
      pend       <= 1'b0;
      pend_rearm <= 1'b0;
    end
  end

  assign hw_set_flag = xact_done && xact_ok && pend && !tok_valid;
  assign hw_rearm    = hw_set_flag && pend_rearm;

  assert_one_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    tok_valid |=> hs_valid);
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
    !tok_valid |=> !hs_valid);
  assert_done_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (xact_done && !tok_valid) |=> !hw_set_flag);
endmodule

// File: rtl/ep_mode_reg.sv
module ep_mode_reg
  import ep_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_en,
  input  logic [REG_W-1:0]  cpu_wr_data,
  input  logic              hw_set_flag,
  input  logic              hw_rearm,
  output logic [MODE_W-1:0] mode,
  output logic              stall,
  output logic              acked,
  output logic [REG_W-1:0]  rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= MODE_OFF;
      stall <= 1'b0;
    end else if (cpu_wr_en) begin
      mode  <= cpu_wr_data[MODE_W-1:0];
      stall <= cpu_wr_data[STALL_B];
    end else if (hw_rearm) begin
      mode  <= MODE_NAK_ALL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                   acked <= 1'b0;
    else if (hw_set_flag)                      acked <= 1'b1;
    else if (cpu_wr_en && !cpu_wr_data[FLAG_B]) acked <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    rd_data[STALL_B]          = stall;
    rd_data[FLAG_B]           = acked;
    rd_data[MODE_W-1:0]       = mode;
    rd_data[RSV_LO +: RSV_W]  = '0;
  end

  assert_rearm_R6: assert property (@(posedge clk) disable iff (rst)
    (hw_rearm && !cpu_wr_en) |=> mode == MODE_NAK_ALL);
  assert_flag_wins_R12: assert property (@(posedge clk) disable iff (rst)
    hw_set_flag |=> acked);
  assert_cpu_mode_wins_R12: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_en |=> mode == $past(cpu_wr_data[MODE_W-1:0]));
endmodule

// File: rtl/ep_hs_ctrl.sv
module ep_hs_ctrl
  import ep_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr_en,
  input  logic [REG_W-1:0] cpu_wr_data,
  output logic [REG_W-1:0] cpu_rd_data,
  input  logic             tok_valid,
  input  logic [1:0]       tok_kind,
  input  logic             pkt_good,
  input  logic             xact_done,
  input  logic             xact_ok,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic             ep_acked
);
  logic [MODE_W-1:0] mode;
  logic              stall;
  logic              acked;
  logic              hw_set_flag;
  logic              hw_rearm;
  verdict_t          verdict;
  hs_e               hs_q;
  tok_e              tok;

  assign tok = tok_e'(tok_kind);

  ep_hs_policy u_policy (
    .mode    (mode),
    .stall   (stall),
    .tok     (tok),
    .good    (pkt_good),
    .verdict (verdict)
  );

  ep_hs_tracker u_tracker (
    .clk         (clk),
    .rst         (rst),
    .tok_valid   (tok_valid),
    .verdict     (verdict),
    .xact_done   (xact_done),
    .xact_ok     (xact_ok),
    .hs_valid    (hs_valid),
    .hs_code     (hs_q),
    .hw_set_flag (hw_set_flag),
    .hw_rearm    (hw_rearm)
  );

  ep_mode_reg u_reg (
    .clk         (clk),
    .rst         (rst),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_wr_data (cpu_wr_data),
    .hw_set_flag (hw_set_flag),
    .hw_rearm    (hw_rearm),
    .mode        (mode),
    .stall       (stall),
    .acked       (acked),
    .rd_data     (cpu_rd_data)
  );

  assign hs_code  = hs_q;
  assign ep_acked = acked;

  assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && mode == MODE_OFF) |=> hs_code == HS_NONE);
  assert_bad_out_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok == TOK_OUT && !pkt_good) |=> hs_code == HS_NONE);
  assert_setup_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok == TOK_SETUP) |=> hs_code == HS_NONE);
  assert_stall_needs_bit_R7: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && !stall) |=> hs_code != HS_STALL);
endmodule

// File: tb/ep_hs_ctrl_test.sv
module ep_hs_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr_en = 1'b0;
  logic [7:0] cpu_wr_data = 8'h00;
  logic [7:0] cpu_rd_data;
  logic       tok_valid = 1'b0;
  logic [1:0] tok_kind = 2'b00;
  logic       pkt_good = 1'b0;
  logic       xact_done = 1'b0;
  logic       xact_ok = 1'b0;
  logic       hs_valid;
  logic [1:0] hs_code;
  logic       ep_acked;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  localparam logic [1:0] K_OUT = 2'b01, K_IN = 2'b10, K_SETUP = 2'b11;
  localparam logic [1:0] C_NONE = 2'b00, C_ACK = 2'b01, C_NAK = 2'b10, C_STALL = 2'b11;

  always #10 clk = ~clk;

  ep_hs_ctrl uut (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_data(cpu_rd_data), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .pkt_good(pkt_good), .xact_done(xact_done), .xact_ok(xact_ok),
    .hs_valid(hs_valid), .hs_code(hs_code), .ep_acked(ep_acked)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic token(string req, logic [1:0] k, logic g, logic [1:0] exp);
    @(negedge clk);
    tok_valid = 1'b1; tok_kind = k; pkt_good = g;
    @(negedge clk);
    tok_valid = 1'b0; tok_kind = 2'b00; pkt_good = 1'b0;
    check(req, {7'd0, hs_valid}, 8'h01);
    check(req, {6'd0, hs_code}, {6'd0, exp});
  endtask

  task automatic done(logic ok);
    @(negedge clk);
    xact_done = 1'b1; xact_ok = ok;
    @(negedge clk);
    xact_done = 1'b0; xact_ok = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", cpu_rd_data, 8'h00);
    check("R1", {7'd0, hs_valid}, 8'h00);
    check("R1", {7'd0, ep_acked}, 8'h00);
  endtask

  task automatic t_reserved();
    wr(8'hFF);
    check("R2", cpu_rd_data, 8'h8F);
    wr(8'h00);
    check("R2", cpu_rd_data, 8'h00);
  endtask

  task automatic t_disabled();
    token("R3", K_OUT, 1'b1, C_NONE);
    token("R3", K_IN, 1'b1, C_NONE);
  endtask

  task automatic t_nak_modes();
    wr(8'h01);
    token("R4", K_IN, 1'b1, C_NAK);
    token("R4", K_OUT, 1'b1, C_NAK);
    wr(8'h81);
    token("R7", K_IN, 1'b1, C_NAK);
    token("R7", K_OUT, 1'b1, C_NAK);
    wr(8'h0E);
    token("R4", K_OUT, 1'b1, C_NAK);
  endtask

  task automatic t_ack_out();
    wr(8'h0B);
    token("R4", K_IN, 1'b1, C_NAK);
    token("R5", K_OUT, 1'b1, C_ACK);
    done(1'b0);
    check("R6", cpu_rd_data, 8'h0B);
    token("R5", K_OUT, 1'b1, C_ACK);
    done(1'b1);
    check("R6", cpu_rd_data, 8'h11);
    check("R6", {7'd0, ep_acked}, 8'h01);
    token("R6", K_OUT, 1'b1, C_NAK);
  endtask

  task automatic t_clear();
    wr(8'h01);
    check("R11", cpu_rd_data, 8'h01);
    check("R11", {7'd0, ep_acked}, 8'h00);
  endtask

  task automatic t_stall();
    wr(8'h8B);
    token("R7", K_OUT, 1'b1, C_STALL);
    done(1'b1);
    check("R7", cpu_rd_data, 8'h8B);
    token("R7", K_IN, 1'b1, C_NAK);
    wr(8'h8D);
    token("R7", K_IN, 1'b1, C_STALL);
  endtask

  task automatic t_ack_in();
    wr(8'h0D);
    token("R4", K_OUT, 1'b1, C_NAK);
    token("R8", K_IN, 1'b1, C_ACK);
    done(1'b1);
    check("R8", cpu_rd_data, 8'h11);
    token("R8", K_IN, 1'b1, C_NAK);
  endtask

  task automatic t_bad_out();
    wr(8'h0B);
    token("R9", K_OUT, 1'b0, C_NONE);
    done(1'b1);
    check("R9", cpu_rd_data, 8'h0B);
  endtask

  task automatic t_setup();
    token("R10", K_SETUP, 1'b1, C_NONE);
    wr(8'h0D);
    token("R10", K_SETUP, 1'b1, C_NONE);
  endtask

  task automatic t_collide();
    wr(8'h0B);
    token("R12", K_OUT, 1'b1, C_ACK);
    @(negedge clk);
    xact_done = 1'b1; xact_ok = 1'b1;
    cpu_wr_en = 1'b1; cpu_wr_data = 8'h0B;
    @(negedge clk);
    xact_done = 1'b0; xact_ok = 1'b0; cpu_wr_en = 1'b0;
    check("R12", cpu_rd_data, 8'h1B);
    check("R12", {7'd0, ep_acked}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_disabled();
    t_nak_modes();
    t_ack_out();
    t_clear();
    t_stall();
    t_ack_in();
    t_bad_out();
    t_setup();
    t_collide();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule